// File: doc/BRIEF.md
# Clock Output Gating Controller

This block sits between a bank of free-running generated clocks and the output pins that carry them. It has two jobs. It parks every output in a low state when the system asks for low-power mode. It also keeps any single output low when that output's enable bit is cleared. Every change of gate state happens while the affected source clock is low, so no shortened high pulse ever reaches an output.

The low-power request is active low and may change at any moment. It first passes through a synchronizer clocked by the CPU-domain reference clock. The synchronized value must then read low on two consecutive rising edges before the block treats it as a real request. A one-bit status output reports when low-power mode is in force and every gated output is parked low. In this model the source clocks are divided copies of the reference clock that change on its rising edges.

Top module: `clkout_gater`

## Requirements
- R1: While reset is asserted, every gated output is low and the status output is low. After reset each gate opens at the first rising edge on which its source clock was sampled low and its enable bit is 1.
- R2: A request that the synchronizer sees low on only one rising edge does not place the block in low-power mode. Outputs keep following their enabled sources and the status stays low.
- R3: The request passes through a two-flop synchronizer. Low-power mode starts on the fourth rising edge after the request falls, counting the first edge that samples it low as edge one. This is the edge at which the synchronized request has read low on two consecutive edges.
- R4: A gated output only ever rises together with its source and falls together with its source. No high pulse is shortened or split.
- R5: In low-power mode, each output is forced low from the first falling transition of its source onward, and it stays low. The status output is 1 exactly when low-power mode is in force and all gates are closed.
- R6: Enable bit i (1 = pass, 0 = block) controls output i. A blocked output is actively held low, and the switch happens only while its source is low.
- R7: After the request returns high, low-power mode ends on the third rising edge. Each output then restarts only at a low phase of its source, so its first pulse is full width.
- R8: An enable or resume that arrives while a source is high has no effect on that output until the source has been sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-domain reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_req_n | input | 1 | Asynchronous low-power request, active low |
| src_clk | input | N_OUT | Free-running generated clocks |
| clk_en | input | N_OUT | Per-output enable from configuration, 1 = pass |
| gated_clk | output | N_OUT | Gated clock outputs |
| pd_active | output | 1 | Low-power mode in force and all outputs parked |

## Verification
A gate register holding the wrong value shows up on the next high phase of its source. That high phase appears as an extra pulse or a missing pulse, within one source period. A wrong synchronizer or qualifier depth moves the edge at which outputs stop or restart by one reference cycle. Directed tests therefore sample the status exactly at the second and third edges around each request transition. A gate that changes during a high phase appears as a pulse edge that does not coincide with a source edge. Every cycle, the outputs are compared with a model that tracks only which source phases are passed.

// File: rtl/clkg_pkg.sv
package clkg_pkg;
  typedef enum logic {
    GATE_SHUT = 1'b0,
    GATE_OPEN = 1'b1
  } gate_state_e;
endpackage

// File: rtl/clkg_sync.sv
module clkg_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = async_in;
    end else begin : g_multi
      always_comb chain_d = {chain_q[LAST-1:0], async_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign sync_out = chain_q[LAST];
endmodule

// File: rtl/clkg_qualify.sv
module clkg_qualify #(
  parameter int SAMPLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_sync_n,
  output logic pd_mode
);
  localparam int CW = $clog2(SAMPLES + 1);
  localparam logic [CW-1:0] FULL = CW'(SAMPLES);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    if (req_sync_n)          cnt_d = '0;
    else if (cnt_q != FULL)  cnt_d = cnt_q + 1'b1;
    else                     cnt_en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign pd_mode = (cnt_q == FULL);

  AST_PD_NEEDS_TWO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_mode) |-> ($past(!req_sync_n) && $past(!req_sync_n, 2))); // R3
  AST_PD_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    req_sync_n |=> !pd_mode); // R7
endmodule

// File: rtl/clkg_gate_cell.sv
module clkg_gate_cell
  import clkg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic src_i,
  input  logic en_i,
  input  logic pd_mode,
  output logic gate_open_o,
  output logic gclk_o
);
  gate_state_e gate_q;
  gate_state_e gate_d;
  logic        want_open;
  logic        load;

  always_comb begin
    want_open = en_i & ~pd_mode;
    load      = ~src_i;
    gate_d    = want_open ? GATE_OPEN : GATE_SHUT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    gate_q <= GATE_SHUT;
    else if (load) gate_q <= gate_d;
  end

  assign gate_open_o = (gate_q == GATE_OPEN);
  assign gclk_o      = src_i & gate_open_o;

  AST_NO_RUNT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gclk_o) |-> $rose(src_i)); // R4
  AST_NO_RUNT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gclk_o) |-> $fell(src_i)); // R4
  AST_PD_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_mode && !src_i) |=> !gclk_o); // R5
  AST_DISABLE_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !src_i) |=> !gclk_o); // R6
  AST_HIGH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(src_i) |-> $stable(gate_q)); // R8
endmodule

// File: rtl/clkout_gater.sv
module clkout_gater #(
  parameter int N_OUT        = 8,
  parameter int SYNC_STAGES  = 2,
  parameter int QUAL_SAMPLES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_req_n,
  input  logic [N_OUT-1:0] src_clk,
  input  logic [N_OUT-1:0] clk_en,
  output logic [N_OUT-1:0] gated_clk,
  output logic             pd_active
);
  logic             req_sync_n;
  logic             pd_mode;
  logic [N_OUT-1:0] gate_open;

  clkg_sync #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(pwr_req_n),
    .sync_out(req_sync_n)
  );

  clkg_qualify #(
    .SAMPLES(QUAL_SAMPLES)
  ) u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_sync_n(req_sync_n),
    .pd_mode   (pd_mode)
  );

  generate
    for (genvar gi = 0; gi < N_OUT; gi++) begin : g_cell
      clkg_gate_cell u_cell (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (src_clk[gi]),
        .en_i       (clk_en[gi]),
        .pd_mode    (pd_mode),
        .gate_open_o(gate_open[gi]),
        .gclk_o     (gated_clk[gi])
      );
    end
  endgenerate

  assign pd_active = pd_mode & ~(|gate_open);

  AST_STATUS_MEANS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    pd_active |-> (gated_clk == '0)); // R5
  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_n |-> (gated_clk == '0 && !pd_active)); // R1
endmodule

// File: tb/sim_clkout_gater.sv
module sim_clkout_gater;
  localparam int CLK_P = 10;
  localparam int N     = 8;
  localparam int QUAL  = 2;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_n;
  logic [N-1:0] src;
  logic [N-1:0] en;
  logic [N-1:0] gated;
  logic         pd_act;

  int  n_chk = 0;
  int  n_err = 0;
  bit  chk_on = 0;
  bit  done = 0;
  int  hcnt [N];

  always #(CLK_P/2) clk = ~clk;

  clkout_gater #(.N_OUT(N), .SYNC_STAGES(2), .QUAL_SAMPLES(QUAL)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_req_n(req_n), .src_clk(src),
    .clk_en(en), .gated_clk(gated), .pd_active(pd_act)
  );

  function automatic int half_of(int i);
    return (i % 3) + 1;
  endfunction

  initial begin
    src = '0;
    for (int i = 0; i < N; i++) hcnt[i] = 0;
  end

  always @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (hcnt[i] == half_of(i) - 1) begin
        hcnt[i] <= 0;
        src[i]  <= ~src[i];
      end else begin
        hcnt[i] <= hcnt[i] + 1;
      end
    end
  end

  // Expected state derived from the requirements: sync depth 2, two low reads, gate moves only in low phase
  logic         r_s1, r_s2;
  int           r_cnt;
  logic [N-1:0] r_gate;

  function automatic bit ref_pd(int c);
    return c == QUAL;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_s1 <= 1'b1; r_s2 <= 1'b1; r_cnt <= 0; r_gate <= '0;
    end else begin
      r_s1 <= req_n;
      r_s2 <= r_s1;
      r_cnt <= r_s2 ? 0 : ((r_cnt < QUAL) ? r_cnt + 1 : r_cnt);
      for (int i = 0; i < N; i++)
        if (!src[i]) r_gate[i] <= en[i] & ~ref_pd(r_cnt);
    end
  end

  function automatic logic [N-1:0] exp_out(logic [N-1:0] s, logic [N-1:0] g);
    return s & g;
  endfunction

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && chk_on) begin
      string tag;
      if (ref_pd(r_cnt))   tag = "R5";
      else if (en != '1)   tag = "R6";
      else                 tag = "R4";
      chk(tag, gated, exp_out(src, r_gate));
      chk("R5_status", {{(N-1){1'b0}}, pd_act},
          {{(N-1){1'b0}}, (ref_pd(r_cnt) && r_gate == '0)});
    end
  end

  task automatic cyc(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog R1 act=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int hold;
    void'($urandom(32'h5EED_0C1C));
    rst_n = 1'b0; req_n = 1'b1; en = '1;
    cyc(3);
    chk("R1", gated, '0);
    chk("R1_status", {{(N-1){1'b0}}, pd_act}, '0);
    rst_n = 1'b1;
    chk_on = 1;
    cyc(20);

    // R2: single-edge low glitch is ignored
    req_n = 1'b0; cyc(1); req_n = 1'b1;
    for (int k = 0; k < 12; k++) begin
      cyc(1);
      chk("R2", {{(N-1){1'b0}}, pd_act}, '0);
    end
    chk("R2_outputs_run", gated | ~src, '1);

    // R3: qualification latency
    req_n = 1'b0;
    cyc(3);
    chk("R3_not_yet", {{(N-1){1'b0}}, pd_act}, '0);
    cyc(9);
    chk("R5_parked", {{(N-1){1'b0}}, pd_act}, {{(N-1){1'b0}}, 1'b1});
    chk("R5_low", gated, '0);
    cyc(10);

    // R7: release latency and full first pulse (model checks pulse shape)
    req_n = 1'b1;
    cyc(2);
    chk("R7_still", {{(N-1){1'b0}}, pd_act}, {{(N-1){1'b0}}, 1'b1});
    cyc(1);
    chk("R7_released", {{(N-1){1'b0}}, pd_act}, '0);
    cyc(20);

    // R6: per-output disable
    en[3] = 1'b0;
    cyc(8);
    for (int k = 0; k < 12; k++) begin
      cyc(1);
      chk("R6", {{(N-1){1'b0}}, gated[3]}, '0);
    end
    en[3] = 1'b1;
    cyc(10);

    // R8: enable arriving during a high phase waits for the low phase
    en[2] = 1'b0;
    cyc(10);
    while (!(src[2] == 1'b1 && hcnt[2] == 0)) cyc(1);
    en[2] = 1'b1;
    cyc(1);
    chk("R8_src_high", {{(N-1){1'b0}}, src[2]}, {{(N-1){1'b0}}, 1'b1});
    chk("R8", {{(N-1){1'b0}}, gated[2]}, '0);
    cyc(10);

    // random phase
    hold = 1;
    for (int k = 0; k < 4000; k++) begin
      cyc(1);
      if ($urandom % 48 == 0) en[$urandom % N] = $urandom % 2;
      hold--;
      if (hold == 0) begin
        req_n = ~req_n;
        hold  = ($urandom % 40) + 1;
      end
    end
    req_n = 1'b1; en = '1;
    cyc(20);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule